// File: doc/BRIEF.md
# Random-Pattern Self-Test Engine

This block is a compact logic self-test core for a circuit under test that exposes one serial scan input and one serial scan output. A 20-bit pseudo-random generator built on the primitive polynomial x^20 + x^3 + 1 produces one test bit per clock. That bit goes to the scan input, so no pattern storage is needed. Each bit that returns from the scan output is folded into a 20-bit serial signature register with eight feedback taps.

A controller loads a programmable shift count on `start` and holds `shift_en` high for exactly that many clocks. It then freezes both registers and raises `done`. At that point the frozen signature is compared with `expected_sig`. `pass` goes high only when they match. The scan chain, capture clocking and any storage of expected signatures sit outside this block.

Top module: `rpst_engine`

## Requirements
- R1: After reset `done`, `pass` and `shift_en` are 0, `signature` is 0, and the generator holds `GEN_SEED`, so `scan_in` equals bit 19 of the seed.
- R2: The generator register g[19:0] shifts toward bit 19 on every shift cycle, taking g[19] XOR g[2] into bit 0. `scan_in` is g[19], and a start reloads g with the nonzero `GEN_SEED`.
- R3: A start clears the signature s[19:0] to 0. On each shift cycle s becomes {s[18:0],0} XOR (`SIG_TAPS` if s[19] XOR `scan_out` is 1, else 0).
- R4: `SIG_TAPS` must have exactly eight bits set, including bit 0, and `GEN_SEED` must be nonzero. Both are checked at elaboration.
- R5: A start with `shift_count` = N > 0 gives exactly N consecutive cycles with `shift_en` = 1. `done` rises on the clock edge that ends the last of them.
- R6: While `done` is 1 and no start arrives, `done` stays 1, `shift_en` stays 0, and `signature` and `scan_in` hold their values.
- R7: `pass` is 1 exactly when `done` is 1 and `signature` equals `expected_sig`. A single flipped response bit makes `pass` 0.
- R8: A `start` pulse while a run is in progress is ignored: the shift count and the result are those of the original run.
- R9: A start with `shift_count` = 0 performs no shift cycle. `done` is 1 one cycle after the start, and `signature` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (ignored while running) |
| shift_count | input | CNT_W | Number of shift cycles for the run |
| expected_sig | input | WIDTH | Signature of a fault-free response |
| scan_out | input | 1 | Response bit returning from the circuit under test |
| scan_in | output | 1 | Pseudo-random test bit sent to the circuit under test |
| shift_en | output | 1 | High during each shift cycle |
| done | output | 1 | Run finished, signature frozen |
| pass | output | 1 | Run finished and signature matched |
| signature | output | WIDTH | Current contents of the signature register |

## Verification
The in-RTL assertions check the following on every cycle:
- the generator never reaches the all-zero state;
- the shift count steps down by one per shift cycle even when `start` pulses mid-run;
- a zero count goes straight to done;
- the signature clears on start and stays frozen while idle or done.

Some properties only the bench's scenarios can show. These are:
- that the exact bit stream and final signature match an independent model for short, medium and long runs;
- that a single flipped response bit, at the first, last or a middle position, turns `pass` off;
- that a restart pulse mid-run leaves the result unchanged.

// File: rtl/rpst_pkg.sv
package rpst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } rpst_state_e;

endpackage

// File: rtl/rpst_prpg.sv
module rpst_prpg #(
   parameter int             W        = 20,
   parameter logic [W-1:0]   TAP_MASK = 20'h80004,
   parameter logic [W-1:0]   SEED     = 20'h5A5A5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         advance,
   output logic         bit_out
);

   logic [W-1:0] gen_q;
   logic [W-1:0] gen_nxt;
   logic         fb;

   initial begin
      a_r4_seed_nonzero: assert (SEED != '0)
         else $error("generator seed must be nonzero");
      a_r4_gen_msb_tap: assert (TAP_MASK[W-1])
         else $error("generator mask must include the last stage");
   end

   assign fb = ^(gen_q & TAP_MASK);

   for (genvar i = 0; i < W; i++) begin : g_next
      if (i == 0) begin : g_head
         assign gen_nxt[i] = fb;
      end else begin : g_body
         assign gen_nxt[i] = gen_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= SEED;
      end else if (load) begin
         gen_q <= SEED;
      end else if (advance) begin
         gen_q <= gen_nxt;
      end
   end

   assign bit_out = gen_q[W-1];

   a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      gen_q != '0);

   a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> gen_q[W-1:1] == $past(gen_q[W-2:0]));

   a_r6_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !load) |=> $stable(gen_q));

endmodule

// File: rtl/rpst_sisr.sv
module rpst_sisr #(
   parameter int             W      = 20,
   parameter logic [W-1:0]   MASK   = 20'hA3225,
   parameter int             NTAPS  = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] sig
);

   logic [W-1:0] sig_q;
   logic [W-1:0] sig_nxt;
   logic         fb;

   initial begin
      a_r4_tap_count: assert ($countones(MASK) == NTAPS)
         else $error("signature mask has wrong number of taps");
      a_r4_tap_const: assert (MASK[0])
         else $error("signature mask must include bit 0");
   end

   assign fb = sig_q[W-1] ^ din;

   for (genvar i = 0; i < W; i++) begin : g_next
      if (i == 0) begin : g_head
         assign sig_nxt[i] = MASK[i] & fb;
      end else begin : g_body
         assign sig_nxt[i] = sig_q[i-1] ^ (MASK[i] & fb);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q <= '0;
      end else if (clear) begin
         sig_q <= '0;
      end else if (shift) begin
         sig_q <= sig_nxt;
      end
   end

   assign sig = sig_q;

   a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> sig_q == '0);

   a_r6_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !shift) |=> $stable(sig_q));

endmodule

// File: rtl/rpst_ctrl.sv
module rpst_ctrl
   import rpst_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] shift_count,
   output logic             load,
   output logic             shift_en,
   output logic             done
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   rpst_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;

   assign load     = start && (state_q != ST_RUN);
   assign shift_en = (state_q == ST_RUN);
   assign done     = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (load) begin
         cnt_q   <= shift_count;
         state_q <= (shift_count == '0) ? ST_DONE : ST_RUN;
      end else if (state_q == ST_RUN) begin
         cnt_q <= cnt_q - CNT_ONE;
         if (cnt_q == CNT_ONE) begin
            state_q <= ST_DONE;
         end
      end
   end

   a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && cnt_q != CNT_ONE)
         |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) - CNT_ONE));

   a_r5_last_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && cnt_q == CNT_ONE) |=> done);

   a_r5_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> cnt_q != '0);

   a_r8_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && start) |-> !load);

   a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (load && shift_count == '0) |=> (done && !shift_en));

   a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

endmodule

// File: rtl/rpst_engine.sv
module rpst_engine #(
   parameter int                 WIDTH     = 20,
   parameter int                 CNT_W     = 16,
   parameter logic [WIDTH-1:0]   GEN_TAPS  = 20'h80004,
   parameter logic [WIDTH-1:0]   GEN_SEED  = 20'h5A5A5,
   parameter logic [WIDTH-1:0]   SIG_TAPS  = 20'hA3225,
   parameter int                 SIG_NTAPS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] shift_count,
   input  logic [WIDTH-1:0] expected_sig,
   input  logic             scan_out,
   output logic             scan_in,
   output logic             shift_en,
   output logic             done,
   output logic             pass,
   output logic [WIDTH-1:0] signature
);

   logic load;

   initial begin
      a_r4_width_min: assert (WIDTH >= 4 && CNT_W >= 1)
         else $error("engine widths too small");
   end

   rpst_ctrl #(
      .CNT_W (CNT_W)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .shift_count (shift_count),
      .load        (load),
      .shift_en    (shift_en),
      .done        (done)
   );

   rpst_prpg #(
      .W        (WIDTH),
      .TAP_MASK (GEN_TAPS),
      .SEED     (GEN_SEED)
   ) prpg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (shift_en),
      .bit_out (scan_in)
   );

   rpst_sisr #(
      .W     (WIDTH),
      .MASK  (SIG_TAPS),
      .NTAPS (SIG_NTAPS)
   ) sisr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .shift (shift_en),
      .din   (scan_out),
      .sig   (signature)
   );

   assign pass = done && (signature == expected_sig);

   a_r6_frozen_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(signature) && $stable(scan_in)));

   a_r7_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !pass);

endmodule

// File: tb/rpst_engine_tb.sv
module rpst_engine_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam int          WIDTH      = 20;
   localparam int          CNT_W      = 16;
   localparam logic [19:0] SEED       = 20'h5A5A5;
   localparam logic [19:0] SIG_TAPS   = 20'hA3225;
   localparam int          WATCHDOG   = 150000;

   localparam int NV = 6;
   localparam int VEC_N [NV] = '{1, 37, 200, 200, 200, 1000};
   localparam int VEC_F [NV] = '{-1, -1, -1, 0, 199, 500};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] shift_count = '0;
   logic [WIDTH-1:0] expected_sig = '0;
   logic             scan_out;
   logic             scan_in;
   logic             shift_en;
   logic             done;
   logic             pass;
   logic [WIDTH-1:0] signature;

   logic [5:0]       chain;
   int               shift_idx;
   int               flip_at = -1;
   logic             clr_chain = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rpst_engine #(
      .WIDTH    (WIDTH),
      .CNT_W    (CNT_W),
      .GEN_SEED (SEED),
      .SIG_TAPS (SIG_TAPS)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .shift_count  (shift_count),
      .expected_sig (expected_sig),
      .scan_out     (scan_out),
      .scan_in      (scan_in),
      .shift_en     (shift_en),
      .done         (done),
      .pass         (pass),
      .signature    (signature)
   );

   // circuit under test stand-in: a six-stage scan chain with optional fault
   always @(posedge clk) begin
      if (clr_chain) begin
         chain     <= '0;
         shift_idx <= 0;
      end else if (shift_en) begin
         chain     <= {chain[4:0], scan_in};
         shift_idx <= shift_idx + 1;
      end
   end
   assign scan_out = chain[5] ^ (flip_at == shift_idx);

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] gen_step(input logic [19:0] g);
      return {g[18:0], g[19] ^ g[2]};
   endfunction

   function automatic logic [19:0] model_sig(input int n, input int flip);
      logic [19:0] g = SEED;
      logic [19:0] s = '0;
      logic [5:0]  c = '0;
      for (int i = 0; i < n; i++) begin
         logic so;
         so = c[5] ^ (i == flip);
         s  = {s[18:0], 1'b0} ^ (((s[19] ^ so) == 1'b1) ? SIG_TAPS : 20'h0);
         c  = {c[4:0], g[19]};
         g  = gen_step(g);
      end
      return s;
   endfunction

   task automatic run_test(input int n, input int flip, input bit restart);
      int          cnt = 0;
      int          guard = 0;
      bit          seq_ok = 1'b1;
      logic [19:0] g = SEED;
      logic [19:0] good = model_sig(n, -1);
      logic [19:0] want = model_sig(n, flip);
      @(negedge clk);
      shift_count  = CNT_W'(n);
      flip_at      = flip;
      expected_sig = good;
      start        = 1'b1;
      clr_chain    = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      clr_chain = 1'b0;
      while (!done && guard < n + 10) begin
         if (shift_en) begin
            if (scan_in !== g[19]) seq_ok = 1'b0;
            g = gen_step(g);
            cnt++;
         end
         if (restart && cnt == 3) begin
            start       = 1'b1;
            shift_count = CNT_W'(5);
         end else begin
            start = 1'b0;
         end
         guard++;
         @(negedge clk);
      end
      start = 1'b0;
      check(done === 1'b1, "R5 done after run", 32'(done), 1);
      check(cnt == n, restart ? "R8 restart ignored shift count" : "R5 shift count",
            32'(cnt), 32'(n));
      check(seq_ok, "R2 test bit stream", 32'(seq_ok), 1);
      check(signature === want, "R3 signature", 32'(signature), 32'(want));
      check(pass === (flip < 0), "R7 pass verdict", 32'(pass), 32'(flip < 0));
   endtask

   initial begin : watchdog
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [19:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(done === 1'b0 && pass === 1'b0 && shift_en === 1'b0, "R1 reset flags",
            {29'b0, done, pass, shift_en}, 0);
      check(signature === '0, "R1 reset signature", 32'(signature), 0);
      check(scan_in === SEED[19], "R1 reset stream bit", 32'(scan_in), 32'(SEED[19]));
      // R4 mask shape used by the model
      check($countones(SIG_TAPS) == 8 && SIG_TAPS[0], "R4 eight signature taps",
            32'($countones(SIG_TAPS)), 8);

      for (int v = 0; v < NV; v++) begin
         run_test(VEC_N[v], VEC_F[v], 1'b0);
      end

      // R6 frozen result after done
      held = signature;
      repeat (5) @(negedge clk);
      check(done === 1'b1 && shift_en === 1'b0, "R6 done held",
            {30'b0, done, shift_en}, 2);
      check(signature === held, "R6 signature frozen", 32'(signature), 32'(held));

      // R7 compare follows expected value
      expected_sig = held ^ 20'h1;
      @(negedge clk);
      check(pass === 1'b0, "R7 mismatch clears pass", 32'(pass), 0);
      expected_sig = held;
      @(negedge clk);
      check(pass === 1'b1, "R7 match sets pass", 32'(pass), 1);

      // R8 start during run ignored
      run_test(50, -1, 1'b1);

      // R9 zero count
      run_test(0, -1, 1'b0);
      check(signature === '0, "R9 zero count signature", 32'(signature), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule